// File: doc/BRIEF.md
# Page Table Walker with Status Bits

The block turns a translation miss into a finished translation by fetching one entry from a single-level page table in memory. A miss arrives as a virtual page number and an access kind (read or write). The walker forms the entry address from a base register and the page number, reads the entry over a request/response memory port and inspects its status bits. A present entry that permits the access produces the physical page number, ready to be loaded into the translation buffer. An absent entry produces a not-present fault. A write to a read-only page produces a protection fault.

On success the walker also keeps the entry's usage bits current. The reference bit is set on every access and the dirty bit is set on a write. The entry is written back to the same address only when one of those bits actually changes; otherwise the write is skipped. Only one walk is in flight at a time.

Every data interface is valid/ready. A transfer happens on a clock edge where both valid and ready are high. A source that raises valid must hold it, and hold its payload unchanged, until the transfer. The walker drives the memory request and result channels this way. The miss, memory-request and result sinks may apply back-pressure for any number of cycles. The base register is a plain input that is sampled when a miss is accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready_o` is 1, and `mem_req_valid_o`, `mem_rsp_ready_o` and `res_valid_o` are 0.
- R2: The entry read is issued with `mem_req_we_o`=0 at address `ptbr_i + vpn*(PTE_W/8)` modulo 2^PA_W. The address uses the value of `ptbr_i` on the cycle the miss is accepted, and later changes of `ptbr_i` do not affect that walk.
- R3: Entry layout: bit 0 is the reference flag, bit 1 the dirty flag, bit 2 the present flag, bit 3 the write-permit flag (1 = writes allowed), and bits [4+PPN_W-1:4] hold the physical page number. The remaining upper bits are carried through a writeback unchanged.
- R4: If the present flag is 0, the result has `res_fault_o`=1, `res_cause_o`=1 (not present), `res_ppn_o`=0, and the faulting page number on `res_vpn_o`. No writeback is issued.
- R5: If the entry is present, the access is a write and the write-permit flag is 0, the result has `res_fault_o`=1, `res_cause_o`=2 (protection) and `res_ppn_o`=0. No writeback is issued.
- R6: Otherwise the result has `res_fault_o`=0, `res_cause_o`=0, `res_ppn_o` equal to the entry's page-number field, and `res_vpn_o` equal to the miss page number.
- R7: On success the updated entry is the old entry with the reference flag set, and with the dirty flag also set when the access is a write. It is written (`mem_req_we_o`=1) to the entry's address before the result is offered, and only if it differs from the old entry.
- R8: While `mem_req_valid_o` or `res_valid_o` is high and not accepted, that valid and its whole payload stay unchanged on the next cycle. A result is held until `res_ready_i` accepts it.
- R9: One walk at a time: at most one of `miss_ready_o`, `mem_req_valid_o`, `mem_rsp_ready_o` and `res_valid_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptbr_i | input | PA_W | Page table base address |
| miss_valid_i | input | 1 | Miss request valid |
| miss_ready_o | output | 1 | Walker can accept a miss |
| miss_vpn_i | input | VPN_W | Missing virtual page number |
| miss_write_i | input | 1 | 1 = the faulting access is a write |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | PA_W | Byte address of the entry |
| mem_req_wdata_o | output | PTE_W | Updated entry for a write |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker waits for read data |
| mem_rsp_data_i | input | PTE_W | Entry read from memory |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted |
| res_fault_o | output | 1 | 1 = walk ended in a fault |
| res_cause_o | output | 2 | 0 none, 1 not present, 2 protection |
| res_vpn_o | output | VPN_W | Page number of this walk |
| res_ppn_o | output | PPN_W | Physical page number, 0 on a fault |

## Verification
The assertions take for granted that the memory answers a read request with exactly one response and sends no response that was not asked for. They also take for granted that `rst_n` is applied before the first miss. The bench keeps to this with a memory model that returns data only after the walker's read has been accepted, and that never responds to writes. The sweep covers every combination of the four status bits and the access kind, at several page numbers and base values including one whose address wraps. Stall lengths on each channel vary from zero to two cycles, and the base register is disturbed in the middle of each walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PROT   = 2'd2
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_CHECK,
    ST_WB,
    ST_RESULT
  } walk_state_e;

  // Entry flag positions (R3)
  localparam int unsigned BIT_REF   = 0;
  localparam int unsigned BIT_DIRTY = 1;
  localparam int unsigned BIT_PRES  = 2;
  localparam int unsigned BIT_WPERM = 3;
  localparam int unsigned PPN_LSB   = 4;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned PA_W  = 16,
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PTE_W = 16
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned ENTRY_BYTES = PTE_W / 8;
  localparam int unsigned SHIFT       = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0] vpn_ext;

  always_comb begin
    vpn_ext = PA_W'(vpn_i);
    addr_o  = base_i + (vpn_ext << SHIFT);
  end
endmodule

// File: rtl/pw_pte_check.sv
module pw_pte_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W = 16,
  parameter int unsigned PPN_W = 8
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             is_write_i,
  output logic             fault_o,
  output logic [1:0]       cause_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [PTE_W-1:0] new_pte_o,
  output logic             need_wb_o
);
  logic present, writable;

  always_comb begin
    present   = pte_i[BIT_PRES];
    writable  = pte_i[BIT_WPERM];
    fault_o   = 1'b0;
    cause_o   = CAUSE_NONE;
    if (!present) begin
      fault_o = 1'b1;
      cause_o = CAUSE_ABSENT;
    end else if (is_write_i && !writable) begin
      fault_o = 1'b1;
      cause_o = CAUSE_PROT;
    end
    ppn_o = fault_o ? '0 : pte_i[PPN_LSB +: PPN_W];

    new_pte_o = pte_i;
    new_pte_o[BIT_REF] = 1'b1;
    if (is_write_i) new_pte_o[BIT_DIRTY] = 1'b1;
    need_wb_o = !fault_o && (new_pte_o != pte_i);
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_fire_i,
  input  logic mreq_fire_i,
  input  logic mrsp_fire_i,
  input  logic res_fire_i,
  input  logic fault_i,
  input  logic need_wb_i,
  output logic in_idle_o,
  output logic in_read_o,
  output logic in_wait_o,
  output logic in_check_o,
  output logic in_wb_o,
  output logic in_result_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (miss_fire_i) state_d = ST_READ;
      ST_READ:   if (mreq_fire_i) state_d = ST_WAIT;
      ST_WAIT:   if (mrsp_fire_i) state_d = ST_CHECK;
      ST_CHECK:  state_d = (!fault_i && need_wb_i) ? ST_WB : ST_RESULT;
      ST_WB:     if (mreq_fire_i) state_d = ST_RESULT;
      ST_RESULT: if (res_fire_i)  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_idle_o   = (state_q == ST_IDLE);
  assign in_read_o   = (state_q == ST_READ);
  assign in_wait_o   = (state_q == ST_WAIT);
  assign in_check_o  = (state_q == ST_CHECK);
  assign in_wb_o     = (state_q == ST_WB);
  assign in_result_o = (state_q == ST_RESULT);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned PA_W  = 16,
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PPN_W = 8,
  parameter int unsigned PTE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  ptbr_i,
  input  logic             miss_valid_i,
  output logic             miss_ready_o,
  input  logic [VPN_W-1:0] miss_vpn_i,
  input  logic             miss_write_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_we_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  output logic [PTE_W-1:0] mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  output logic             mem_rsp_ready_o,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic             res_fault_o,
  output logic [1:0]       res_cause_o,
  output logic [VPN_W-1:0] res_vpn_o,
  output logic [PPN_W-1:0] res_ppn_o
);
  logic             in_idle, in_read, in_wait, in_check, in_wb, in_result;
  logic             miss_fire, mreq_fire, mrsp_fire, res_fire;
  logic [VPN_W-1:0] vpn_q;
  logic             write_q;
  logic [PA_W-1:0]  addr_q, addr_d;
  logic [PTE_W-1:0] pte_q;
  logic             chk_fault, chk_wb;
  logic [1:0]       chk_cause;
  logic [PPN_W-1:0] chk_ppn;
  logic [PTE_W-1:0] chk_new;

  assign miss_fire = miss_valid_i && miss_ready_o;
  assign mreq_fire = mem_req_valid_o && mem_req_ready_i;
  assign mrsp_fire = mem_rsp_valid_i && mem_rsp_ready_o;
  assign res_fire  = res_valid_o && res_ready_i;

  pw_addr_gen #(.PA_W(PA_W), .VPN_W(VPN_W), .PTE_W(PTE_W)) u_addr (
    .base_i (ptbr_i),
    .vpn_i  (miss_vpn_i),
    .addr_o (addr_d)
  );

  pw_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_check (
    .pte_i      (pte_q),
    .is_write_i (write_q),
    .fault_o    (chk_fault),
    .cause_o    (chk_cause),
    .ppn_o      (chk_ppn),
    .new_pte_o  (chk_new),
    .need_wb_o  (chk_wb)
  );

  pw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_fire_i (miss_fire),
    .mreq_fire_i (mreq_fire),
    .mrsp_fire_i (mrsp_fire),
    .res_fire_i  (res_fire),
    .fault_i     (chk_fault),
    .need_wb_i   (chk_wb),
    .in_idle_o   (in_idle),
    .in_read_o   (in_read),
    .in_wait_o   (in_wait),
    .in_check_o  (in_check),
    .in_wb_o     (in_wb),
    .in_result_o (in_result)
  );

  // Walk context, captured at acceptance (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
    end else if (miss_fire) begin
      vpn_q   <= miss_vpn_i;
      write_q <= miss_write_i;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pte_q <= '0;
    else if (mrsp_fire) pte_q <= mem_rsp_data_i;
  end

  assign miss_ready_o    = in_idle;
  assign mem_req_valid_o = in_read || in_wb;
  assign mem_req_we_o    = in_wb;
  assign mem_req_addr_o  = addr_q;
  assign mem_req_wdata_o = chk_new;
  assign mem_rsp_ready_o = in_wait;

  assign res_valid_o = in_result;
  assign res_fault_o = chk_fault;
  assign res_cause_o = chk_cause;
  assign res_vpn_o   = vpn_q;
  assign res_ppn_o   = chk_ppn;

  logic unused_check;
  assign unused_check = in_check;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W  = 16,
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PPN_W = 8,
  parameter int unsigned PTE_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_we_o,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic [PTE_W-1:0] mem_req_wdata_o,
  input logic             mem_rsp_ready_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic             res_fault_o,
  input logic [1:0]       res_cause_o,
  input logic [VPN_W-1:0] res_vpn_o,
  input logic [PPN_W-1:0] res_ppn_o
);
  p_mreq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)
       && $stable(mem_req_wdata_o)));

  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_fault_o) && $stable(res_cause_o)
       && $stable(res_vpn_o) && $stable(res_ppn_o)));

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_ready_o, mem_req_valid_o, mem_rsp_ready_o, res_valid_o}));

  p_wb_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_we_o) |-> (mem_req_wdata_o[0] && mem_req_wdata_o[2]));

  p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_fault_o) |-> (res_cause_o != 2'd0 && res_ppn_o == '0));

  p_ok_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_fault_o) |-> (res_cause_o == 2'd0));

  p_wb_then_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_we_o && mem_req_ready_i) |=> res_valid_o);
endmodule

bind pt_walker pt_walker_chk #(
  .PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .PTE_W(PTE_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_ready_o    (miss_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .res_valid_o     (res_valid_o),
  .res_ready_i     (res_ready_i),
  .res_fault_o     (res_fault_o),
  .res_cause_o     (res_cause_o),
  .res_vpn_o       (res_vpn_o),
  .res_ppn_o       (res_ppn_o)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int unsigned PA_W  = 16;
  localparam int unsigned VPN_W = 6;
  localparam int unsigned PPN_W = 8;
  localparam int unsigned PTE_W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PA_W-1:0]  ptbr_i = '0;
  logic             miss_valid_i = 1'b0;
  logic             miss_ready_o;
  logic [VPN_W-1:0] miss_vpn_i = '0;
  logic             miss_write_i = 1'b0;
  logic             mem_req_valid_o;
  logic             mem_req_ready_i = 1'b0;
  logic             mem_req_we_o;
  logic [PA_W-1:0]  mem_req_addr_o;
  logic [PTE_W-1:0] mem_req_wdata_o;
  logic             mem_rsp_valid_i = 1'b0;
  logic             mem_rsp_ready_o;
  logic [PTE_W-1:0] mem_rsp_data_i = '0;
  logic             res_valid_o;
  logic             res_ready_i = 1'b0;
  logic             res_fault_o;
  logic [1:0]       res_cause_o;
  logic [VPN_W-1:0] res_vpn_o;
  logic [PPN_W-1:0] res_ppn_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker #(.PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .PTE_W(PTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptbr_i(ptbr_i),
    .miss_valid_i(miss_valid_i), .miss_ready_o(miss_ready_o),
    .miss_vpn_i(miss_vpn_i), .miss_write_i(miss_write_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .mem_rsp_data_i(mem_rsp_data_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i),
    .res_fault_o(res_fault_o), .res_cause_o(res_cause_o),
    .res_vpn_o(res_vpn_o), .res_ppn_o(res_ppn_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [PA_W-1:0] base, input logic [VPN_W-1:0] vpn,
                      input bit wr, input logic [PTE_W-1:0] pte, input int d);
    logic [PA_W-1:0]  exp_addr;
    bit               exp_fault, exp_wb;
    logic [1:0]       exp_cause;
    logic [PPN_W-1:0] exp_ppn;
    logic [PTE_W-1:0] exp_new;
    bit               saw_wb;

    exp_addr = PA_W'(base + PA_W'(vpn) * (PTE_W/8));
    if (!pte[2]) begin
      exp_fault = 1; exp_cause = 2'd1; exp_ppn = '0;
    end else if (wr && !pte[3]) begin
      exp_fault = 1; exp_cause = 2'd2; exp_ppn = '0;
    end else begin
      exp_fault = 0; exp_cause = 2'd0; exp_ppn = pte[11:4];
    end
    exp_new = pte | PTE_W'(1) | (wr ? PTE_W'(2) : PTE_W'(0));
    exp_wb  = !exp_fault && (exp_new != pte);

    @(negedge clk);
    ptbr_i = base; miss_vpn_i = vpn; miss_write_i = wr; miss_valid_i = 1'b1;
    while (!miss_ready_o) @(negedge clk);
    @(negedge clk);
    miss_valid_i = 1'b0;
    ptbr_i = ~base;  // disturbance after acceptance (R2)
    miss_vpn_i = ~vpn;
    while (!mem_req_valid_o) @(negedge clk);
    check(mem_req_addr_o == exp_addr, "R2 read address", 32'(mem_req_addr_o), 32'(exp_addr));
    check(mem_req_we_o == 1'b0, "R2 read kind", 32'(mem_req_we_o), 0);
    check(miss_ready_o == 1'b0, "R9 busy during walk", 32'(miss_ready_o), 0);
    repeat (d) @(negedge clk);
    mem_req_ready_i = 1'b1;
    @(negedge clk);
    mem_req_ready_i = 1'b0;
    repeat (d) @(negedge clk);
    mem_rsp_data_i = pte; mem_rsp_valid_i = 1'b1;
    while (!mem_rsp_ready_o) @(negedge clk);
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    while (!mem_req_valid_o && !res_valid_o) @(negedge clk);
    saw_wb = mem_req_valid_o;
    check(saw_wb == exp_wb, "R7 writeback issued", 32'(saw_wb), 32'(exp_wb));
    if (saw_wb) begin
      check(mem_req_we_o == 1'b1, "R7 write kind", 32'(mem_req_we_o), 1);
      check(mem_req_addr_o == exp_addr, "R7 write address", 32'(mem_req_addr_o), 32'(exp_addr));
      check(mem_req_wdata_o == exp_new, "R3 R7 updated entry", 32'(mem_req_wdata_o), 32'(exp_new));
      repeat (d) @(negedge clk);
      mem_req_ready_i = 1'b1;
      @(negedge clk);
      mem_req_ready_i = 1'b0;
    end
    while (!res_valid_o) @(negedge clk);
    repeat (d) @(negedge clk);
    check(res_valid_o == 1'b1, "R8 result held", 32'(res_valid_o), 1);
    check(res_fault_o == exp_fault, exp_fault ? "R4 R5 fault flag" : "R6 fault flag",
          32'(res_fault_o), 32'(exp_fault));
    check(res_cause_o == exp_cause, exp_cause == 1 ? "R4 cause" : (exp_cause == 2 ? "R5 cause" : "R6 cause"),
          32'(res_cause_o), 32'(exp_cause));
    check(res_ppn_o == exp_ppn, "R6 ppn", 32'(res_ppn_o), 32'(exp_ppn));
    check(res_vpn_o == vpn, "R4 R6 vpn", 32'(res_vpn_o), 32'(vpn));
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    check(res_valid_o == 1'b0 && miss_ready_o == 1'b1, "R9 back to idle",
          32'({res_valid_o, miss_ready_o}), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(miss_ready_o == 1'b1, "R1 reset ready", 32'(miss_ready_o), 1);
    check({mem_req_valid_o, mem_rsp_ready_o, res_valid_o} == 3'b000, "R1 reset outputs",
          32'({mem_req_valid_o, mem_rsp_ready_o, res_valid_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(miss_ready_o == 1'b1 && !mem_req_valid_o && !res_valid_o, "R1 idle after reset",
          32'({miss_ready_o, mem_req_valid_o, res_valid_o}), 32'h4);
    for (int vi = 0; vi < 4; vi++) begin
      logic [VPN_W-1:0] vpn;
      logic [PA_W-1:0]  base;
      vpn  = (vi == 0) ? 6'd0 : (vi == 1) ? 6'd1 : (vi == 2) ? 6'd37 : 6'd63;
      base = (vi == 3) ? 16'hFFF0 : PA_W'(16'h2000 + vi * 16'h0100);
      for (int c = 0; c < 32; c++) begin
        logic [PTE_W-1:0] pte;
        pte = {4'(c ^ vi), 8'(vpn * 3 + c), 4'(c)};
        walk(base, vpn, c[4], pte, (c + vi) % 3);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule